// File: doc/BRIEF.md
# Run-Length Sample Encoder with Channel-Group Packing

This block records 32-bit logic-analyser samples during a capture window and, when the window closes, plays them out as a byte stream for a serial transmitter. The 32 sample bits form four 8-bit channel groups. Group g covers bits 8g+7 down to 8g. The `cfg_grp_off` bit g set to 1 disables group g. The bytes of disabled groups are never transmitted, so every stored word shrinks to as many bytes as there are enabled groups. The stream starts with the newest stored word and ends with the oldest.

With `cfg_rle` set, runs of identical samples collapse into two words: the sample itself, then a count word. The count word carries how many extra times that sample repeated, and a flag bit marks it as a count. The flag is the top bit of the highest enabled byte. In sample words that bit is always sent as 0, so a receiver can tell the two kinds of word apart.

A capture starts with `cap_start` in idle and ends with `cap_stop`. When the capture ends, any open run is closed and readout begins on its own. The transmitter paces the stream with `tx_ready`. `rd_done` pulses when the last byte has left.

Top module: `rle_sample_encoder`

## Requirements
- R1: After reset, `tx_valid` and `rd_done` are 0.
- R2: With run-length mode off, each sample accepted during a capture becomes one stored word. The readout sends the words newest first.
- R3: For each word, the block sends only the bytes of enabled groups, lowest group first. With every group disabled, no byte is sent and `rd_done` still pulses.
- R4: With run-length mode on, a run of k equal samples is stored as the sample word. If k > 1, it is followed by a count word holding k-1. Because the readout is newest first, the count word leaves before its sample.
- R5: A count word with n enabled groups is the count in the low 8n-1 bits with bit 8n-1 set to 1. In the stream, that bit is the top bit of the highest enabled byte. In run-length mode, a sample word always carries 0 in that bit.
- R6: A run's count never exceeds the smaller of `CNT_MAX` and 2^(8n-1)-1. A further equal sample closes the run and starts a new one with a fresh sample word.
- R7: Ending the capture closes an open run and stores its count word if the count is non-zero.
- R8: When more than `DEPTH` words are produced, only the newest `DEPTH` words are sent.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` stays unchanged. No byte is lost or repeated.
- R10: Samples are taken only while capturing. A sample presented in the same cycle as `cap_stop` is ignored, and so are samples in idle. `tx_valid` is only high during readout. `rd_done` is a one-cycle pulse.
- R11: Run detection uses only the enabled groups. Samples that differ only in disabled groups form one run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rle | input | 1 | 1 enables run-length compression; hold stable outside idle |
| cfg_grp_off | input | 4 | Bit g = 1 disables byte group g; hold stable outside idle |
| cap_start | input | 1 | Starts a capture (accepted in idle), clears the buffer |
| cap_stop | input | 1 | Ends the capture and triggers readout |
| smp_valid | input | 1 | A sample is present on `smp_data` |
| smp_data | input | 32 | Sample value |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | `tx_data` holds a byte to send |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| rd_done | output | 1 | One-cycle pulse when readout is complete |

## Verification
The bench sweeps all sixteen group-disable settings in both modes. It runs six sample patterns:
- Distinct samples separate pure reordering and byte selection.
- Runs of three expose count words and their flag position.
- A long constant run hits the count limit and tells saturation apart from a missed close.
- An over-long stream shows that the oldest words are dropped rather than the newest.
- A stream that varies only in one byte forms a single run exactly when that group is off.
- A single sample checks the shortest readout.

Irregular `tx_ready` gaps and junk samples in idle and on the stop cycle show that backpressure and ignored inputs change nothing in the stream.

// File: rtl/rle_pkg.sv
// Package: shared types and pure helper functions for the run-length sample
// encoder. Assumes four 8-bit channel groups in a 32-bit sample.
package rle_pkg;

    localparam int NGRP  = 4;
    localparam int GRP_W = 8;
    localparam int SMP_W = NGRP * GRP_W;

    // One stored word: a sample or a repeat count
    typedef struct packed {
        logic             is_cnt;
        logic [SMP_W-1:0] data;
    } rle_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAP,
        ST_ARM,
        ST_READ
    } enc_state_t;

    // Number of enabled groups
    function automatic int unsigned grp_count(input logic [NGRP-1:0] off);
        int unsigned n = 0;
        for (int g = 0; g < NGRP; g++)
            if (!off[g]) n++;
        return n;
    endfunction

    // Bits of the sample that take part in storage and run comparison
    function automatic logic [SMP_W-1:0] keep_mask(input logic [NGRP-1:0] off,
                                                   input logic rle);
        logic [SMP_W-1:0] m = '0;
        int hi = -1;
        for (int g = 0; g < NGRP; g++) begin
            if (!off[g]) begin
                m[g*GRP_W +: GRP_W] = '1;
                hi = g;
            end
        end
        if (rle && hi >= 0)
            m[hi*GRP_W + GRP_W - 1] = 1'b0;
        return m;
    endfunction

    // Largest count that fits the packed width, capped by cmax
    function automatic logic [SMP_W-1:0] cnt_limit(input logic [NGRP-1:0] off,
                                                   input logic [SMP_W-1:0] cmax);
        int unsigned n = grp_count(off);
        logic [SMP_W-1:0] lim;
        if (n == 0) return '0;
        lim = (SMP_W'(1) << (GRP_W*n - 1)) - SMP_W'(1);
        return (cmax < lim) ? cmax : lim;
    endfunction

    // Spread a packed value over the enabled group positions, lowest first
    function automatic logic [SMP_W-1:0] scatter(input logic [SMP_W-1:0] p,
                                                 input logic [NGRP-1:0] off);
        logic [SMP_W-1:0] o = '0;
        int j = 0;
        for (int g = 0; g < NGRP; g++) begin
            if (!off[g]) begin
                o[g*GRP_W +: GRP_W] = GRP_W'(p >> (GRP_W*j));
                j++;
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/rle_run_encoder.sv
// Module: rle_run_encoder
// Turns accepted samples into stored words. In plain mode every sample is
// one word. In run-length mode the first sample of a run is written at once
// and the run's count word is written when the run closes (value change,
// count limit, or flush). It may issue two writes in one cycle (count of the
// old run, then the new sample). Assumes take and flush are never both high
// and that configuration is stable from clear to flush.
module rle_run_encoder
    import rle_pkg::*;
#(
    parameter logic [31:0] CNT_MAX = 32'h7FFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [SMP_W-1:0] smp,
    input  logic             flush,
    input  logic             rle_on,
    input  logic [NGRP-1:0]  grp_off,
    output logic [1:0]       wr_n,
    output rle_word_t        wr0,
    output rle_word_t        wr1
);

    logic             have_run;
    logic [SMP_W-1:0] run_val;
    logic [SMP_W-1:0] run_cnt;
    logic [SMP_W-1:0] vis;
    logic [SMP_W-1:0] lim;
    logic             extend;

    // Visible value of the sample and the run limit for this configuration
    always_comb begin
        vis    = smp & keep_mask(grp_off, rle_on);
        lim    = cnt_limit(grp_off, CNT_MAX);
        extend = have_run && (vis == run_val) && (run_cnt < lim);
    end

    // Decide which words to write this cycle
    always_comb begin
        wr_n = 2'd0;
        wr0  = '0;
        wr1  = '0;
        if (take) begin
            if (!rle_on || !have_run) begin
                wr_n = 2'd1;
                wr0  = '{is_cnt: 1'b0, data: vis};
            end else if (!extend) begin
                if (run_cnt != '0) begin
                    wr_n = 2'd2;
                    wr0  = '{is_cnt: 1'b1, data: run_cnt};
                    wr1  = '{is_cnt: 1'b0, data: vis};
                end else begin
                    wr_n = 2'd1;
                    wr0  = '{is_cnt: 1'b0, data: vis};
                end
            end
        end else if (flush && rle_on && have_run && run_cnt != '0) begin
            wr_n = 2'd1;
            wr0  = '{is_cnt: 1'b1, data: run_cnt};
        end
    end

    // Track the open run
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_run <= 1'b0;
            run_val  <= '0;
            run_cnt  <= '0;
        end else if (take && rle_on) begin
            if (extend) begin
                run_cnt <= run_cnt + 1'b1;
            end else begin
                have_run <= 1'b1;
                run_val  <= vis;
                run_cnt  <= '0;
            end
        end
    end

    // R6
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> run_cnt <= lim);

endmodule

// File: rtl/rle_word_buffer.sv
// Module: rle_word_buffer
// Circular store of the most recent DEPTH words, written up to two per
// cycle. A read pass walks from the newest word back to the oldest that
// is still held. Assumes rd_start is not given in the same cycle as writes.
module rle_word_buffer
    import rle_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] wr_n,
    input  rle_word_t  wr0,
    input  rle_word_t  wr1,
    input  logic       rd_start,
    input  logic       rd_take,
    output logic       rd_valid,
    output rle_word_t  rd_word
);

    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FILL_W = PTR_W + 1;

    rle_word_t         mem [DEPTH];
    logic [PTR_W-1:0]  wp;
    logic [PTR_W-1:0]  rd_ptr;
    logic [FILL_W-1:0] fill;
    logic [FILL_W-1:0] rd_left;
    logic [PTR_W-1:0]  wp_next1;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH-1) : p - 1'b1;
    endfunction

    assign wp_next1 = ptr_inc(wp);
    assign rd_valid = (rd_left != '0);
    assign rd_word  = mem[rd_ptr];

    // Store incoming words
    always_ff @(posedge clk) begin
        if (wr_n != 2'd0) mem[wp] <= wr0;
        if (wr_n == 2'd2) mem[wp_next1] <= wr1;
    end

    // Advance the write pointer and the saturating fill count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wp   <= '0;
            fill <= '0;
        end else begin
            if (wr_n == 2'd1) wp <= wp_next1;
            else if (wr_n == 2'd2) wp <= ptr_inc(wp_next1);
            if (int'(fill) + int'(wr_n) > DEPTH) fill <= FILL_W'(DEPTH);
            else fill <= fill + FILL_W'(wr_n);
        end
    end

    // Walk the read pointer from newest to oldest
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr  <= '0;
            rd_left <= '0;
        end else if (rd_start) begin
            rd_ptr  <= ptr_dec(wp);
            rd_left <= fill;
        end else if (rd_take) begin
            rd_ptr  <= ptr_dec(rd_ptr);
            rd_left <= rd_left - 1'b1;
        end
    end

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));

    // R2
    read_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |-> rd_valid);

endmodule

// File: rtl/rle_byte_packer.sv
// Module: rle_byte_packer
// Sends one word as the bytes of its enabled groups, lowest group first.
// A count word is first packed into the reduced width with its flag at the
// top packed bit and then spread over the enabled groups. Takes a new word
// only when the previous one is fully sent. Assumes grp_off stable.
module rle_byte_packer
    import rle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NGRP-1:0]  grp_off,
    input  logic             in_valid,
    input  rle_word_t        in_word,
    output logic             in_take,
    output logic [GRP_W-1:0] tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             busy
);

    logic [NGRP-1:0]  pend;
    logic [SMP_W-1:0] held;
    logic [1:0]       cur;
    logic [SMP_W-1:0] cnt_pk;
    int unsigned      n_en;

    // Pick the lowest pending group
    always_comb begin
        cur = '0;
        for (int g = NGRP-1; g >= 0; g--)
            if (pend[g]) cur = 2'(g);
    end

    // Build the packed count value with its flag bit
    always_comb begin
        n_en   = grp_count(grp_off);
        cnt_pk = in_word.data;
        if (n_en != 0)
            cnt_pk = in_word.data | (SMP_W'(1) << (GRP_W*n_en - 1));
    end

    assign busy     = (pend != '0);
    assign tx_valid = busy;
    assign in_take  = in_valid && !busy;
    assign tx_data  = held[cur*GRP_W +: GRP_W];

    // Load a word or retire the byte just sent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            held <= '0;
        end else if (in_take) begin
            pend <= ~grp_off;
            held <= in_word.is_cnt ? scatter(cnt_pk, grp_off) : in_word.data;
        end else if (tx_valid && tx_ready) begin
            pend[cur] <= 1'b0;
        end
    end

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R3
    pend_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !grp_off[cur]);

endmodule

// File: rtl/rle_sample_encoder.sv
// Module: rle_sample_encoder (top)
// Capture, compress and play back 32-bit samples as a byte stream, newest
// word first. Sequencing: idle -> capture -> arm (latch read window) ->
// readout -> idle. Assumes cfg_rle and cfg_grp_off change only in idle.
module rle_sample_encoder
    import rle_pkg::*;
#(
    parameter int          DEPTH   = 16,
    parameter logic [31:0] CNT_MAX = 32'h7FFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_rle,
    input  logic [3:0]  cfg_grp_off,
    input  logic        cap_start,
    input  logic        cap_stop,
    input  logic        smp_valid,
    input  logic [31:0] smp_data,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        rd_done
);

    enc_state_t state;
    logic       clear, take, flush;
    logic [1:0] wr_n;
    rle_word_t  wr0, wr1, rd_word;
    logic       rd_valid, rd_take, pk_busy;

    assign clear   = (state == ST_IDLE) && cap_start;
    assign take    = (state == ST_CAP) && smp_valid && !cap_stop;
    assign flush   = (state == ST_CAP) && cap_stop;
    assign rd_done = (state == ST_READ) && !rd_valid && !pk_busy;

    // Phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (cap_start) state <= ST_CAP;
                ST_CAP:  if (cap_stop)  state <= ST_ARM;
                ST_ARM:  state <= ST_READ;
                ST_READ: if (rd_done)   state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    rle_run_encoder #(.CNT_MAX(CNT_MAX)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .take    (take),
        .smp     (smp_data),
        .flush   (flush),
        .rle_on  (cfg_rle),
        .grp_off (cfg_grp_off),
        .wr_n    (wr_n),
        .wr0     (wr0),
        .wr1     (wr1)
    );

    rle_word_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .wr_n     (wr_n),
        .wr0      (wr0),
        .wr1      (wr1),
        .rd_start (state == ST_ARM),
        .rd_take  (rd_take),
        .rd_valid (rd_valid),
        .rd_word  (rd_word)
    );

    rle_byte_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .grp_off  (cfg_grp_off),
        .in_valid ((state == ST_READ) && rd_valid),
        .in_word  (rd_word),
        .in_take  (rd_take),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .busy     (pk_busy)
    );

    // R10
    tx_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> state == ST_READ);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

endmodule

// File: tb/rle_sample_encoder_bench.sv
module rle_sample_encoder_bench;

    localparam int          DEPTH = 16;
    localparam logic [31:0] CMAX  = 32'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rle = 1'b0;
    logic [3:0]  cfg_grp_off = 4'h0;
    logic        cap_start = 1'b0, cap_stop = 1'b0, smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_ready = 1'b0, rd_done;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    rle_sample_encoder #(.DEPTH(DEPTH), .CNT_MAX(CMAX)) u_rle_sample_encoder (
        .clk(clk), .rst_n(rst_n), .cfg_rle(cfg_rle), .cfg_grp_off(cfg_grp_off),
        .cap_start(cap_start), .cap_stop(cap_stop), .smp_valid(smp_valid),
        .smp_data(smp_data), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rd_done(rd_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] pat_smp(input int p, input int i);
        logic [7:0] b;
        b = 8'(i + 1);
        case (p)
            1: b = 8'(i / 3 + 1);
            2: return 32'hC3A5_5A3C;
            4: return {8'h9A, 8'(i + 3), 8'h56, 8'h78};
            default: ;
        endcase
        return {8'h80 | b, b ^ 8'h5A, b + 8'h20, b};
    endfunction

    // Expected byte stream from the requirements
    function automatic void build_exp(input int p, input int len, input bit rle,
                                      input logic [3:0] off, ref logic [7:0] q[$]);
        logic [31:0] keep, lim, rv, cnt, v, pk;
        logic [32:0] words[$];
        int n, hi;
        bit have;
        n = 0; hi = -1; keep = '0;
        for (int g = 0; g < 4; g++)
            if (!off[g]) begin n++; hi = g; keep[g*8 +: 8] = 8'hFF; end
        if (rle && hi >= 0) keep[hi*8 + 7] = 1'b0;
        lim = (n == 0) ? 0 : ((32'h1 << (8*n - 1)) - 1);
        if (CMAX < lim) lim = CMAX;
        have = 0; rv = 0; cnt = 0;
        for (int i = 0; i < len; i++) begin
            v = pat_smp(p, i) & keep;
            if (!rle) words.push_back({1'b0, v});
            else if (have && v == rv && cnt < lim) cnt++;
            else begin
                if (have && cnt != 0) words.push_back({1'b1, cnt});
                words.push_back({1'b0, v});
                have = 1; rv = v; cnt = 0;
            end
        end
        if (rle && have && cnt != 0) words.push_back({1'b1, cnt});
        q.delete();
        for (int k = words.size() - 1; k >= 0 && k >= words.size() - DEPTH; k--) begin
            if (words[k][32]) begin
                pk = words[k][31:0] | (32'h1 << (8*n - 1));
                for (int j = 0; j < n; j++) q.push_back(pk[8*j +: 8]);
            end else begin
                for (int g = 0; g < 4; g++)
                    if (!off[g]) q.push_back(words[k][8*g +: 8]);
            end
        end
    endfunction

    task automatic run_case(input int p, input int len, input bit rle, input logic [3:0] off);
        logic [7:0] expq[$], got[$];
        string tag;
        bit seen_done, stall_prev;
        logic [7:0] prev_d;
        int first_bad;
        case (p)
            0: tag = "R2"; 1: tag = "R4 R7"; 2: tag = "R6";
            3: tag = "R8"; 4: tag = "R11"; default: tag = "R3";
        endcase
        if (rle) tag = {tag, " R5"};
        @(negedge clk);
        cfg_rle = rle; cfg_grp_off = off;
        smp_valid = 1; smp_data = 32'h0BAD_F00D;          // R10: ignored in idle
        @(negedge clk);
        cap_start = 1; smp_valid = 0;
        @(negedge clk);
        cap_start = 0;
        for (int i = 0; i < len; i++) begin
            if (i % 4 == 3) begin
                smp_valid = 0; smp_data = 32'h1357_9BDF;
                @(negedge clk);
            end
            smp_valid = 1; smp_data = pat_smp(p, i);
            @(negedge clk);
        end
        cap_stop = 1; smp_valid = 1; smp_data = 32'hDEAD_BEEF;   // R10: ignored
        @(negedge clk);
        cap_stop = 0; smp_valid = 0;
        seen_done = 0; stall_prev = 0; prev_d = 0;
        for (int t = 0; t < 2000 && !seen_done; t++) begin
            if (stall_prev) chk(tx_valid && tx_data == prev_d, "R9 hold", longint'(tx_data), longint'(prev_d));
            tx_ready = (cyc % 5 != 2) && (cyc % 7 != 0);
            cyc++;
            if (tx_valid && tx_ready) got.push_back(tx_data);
            stall_prev = tx_valid && !tx_ready;
            prev_d = tx_data;
            if (rd_done) seen_done = 1;
            else @(negedge clk);
        end
        chk(seen_done, "R3 done", longint'(seen_done), 1);
        @(negedge clk);
        chk(!rd_done && !tx_valid, "R10 pulse", longint'(rd_done), 0);
        tx_ready = 0;
        build_exp(p, len, rle, off, expq);
        chk(got.size() == expq.size(), {tag, " R3 count"}, got.size(), expq.size());
        first_bad = -1;
        for (int k = 0; k < got.size() && k < expq.size(); k++)
            if (first_bad < 0 && got[k] != expq[k]) first_bad = k;
        if (first_bad >= 0)
            chk(0, {tag, " bytes"}, longint'(got[first_bad]), longint'(expq[first_bad]));
        else
            chk(1, {tag, " bytes"}, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        summary();
    end

    initial begin
        int lens[6] = '{6, 9, 13, 20, 7, 1};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!tx_valid, "R1 tx_valid", longint'(tx_valid), 0);
        chk(!rd_done, "R1 rd_done", longint'(rd_done), 0);
        for (int r = 0; r < 2; r++)
            for (int o = 0; o < 16; o++)
                for (int p = 0; p < 6; p++)
                    run_case(p, lens[p], bit'(r), 4'(o));
        summary();
    end

endmodule